// File: doc/BRIEF.md
# Erase-Block Protection Manager

This block holds the write-protection state of every erase block in a 22-bit word-addressed flash array. The array has 127 large blocks of 32 KWord. Above them, the topmost 32 KWord region is split into 8 small blocks of 4 KWord. Each block carries two flags: a locked flag and a locked-down flag. Software changes them with a two-write configuration sequence. The first write carries a setup code. The second write carries a confirm code and is sent to any word address inside the target block.

A hardware write-protect input decides whether a locked-down block may be unlocked again. Each block's flags can be read combinationally from a status address. A program/erase permit port answers each request one cycle later with either a grant or a deny. A deny is the protected-block error that the surrounding controller records. Reset returns every block to the locked state and removes every lock-down.

Top module: `lkm_top`

## Requirements
- R1: While `rst_n` is low, and directly after it rises, every block reads locked=1 and locked-down=0.
- R2: A write of code 60h arms the sequence. The next write is the confirm. A confirm of 01h sets the locked flag of the block that the confirm address falls in. A confirm code written without a preceding 60h changes nothing.
- R3: A confirm of 2Fh sets both the locked and the locked-down flags of the addressed block.
- R4: A confirm of D0h clears the locked flag, with one exception. When `wp_n` is low and the block is locked-down, the command is ignored. When `wp_n` is high, D0h clears the locked flag and leaves the locked-down flag as it was.
- R5: A `pe_req` sampled at a clock edge yields exactly one of `pe_grant` or `pe_deny` in the following cycle. The answer is a grant when the block's locked flag is 0, whatever its locked-down flag says.
- R6: A confirm code other than 01h, D0h or 2Fh leaves every flag unchanged and raises `seq_err` for exactly the one cycle after the confirm write.
- R7: When a confirm and a permit request hit the same block in the same cycle, the permit answer is based on the flags from before that confirm.
- R8: Addresses with bits [21:15] below 127 select large block number bits[21:15]. Addresses with bits [21:15] equal to 127 select block 127 plus bits[14:12]. Every address within one block behaves identically.
- R9: `st_flags` shows the flags of the block containing `st_addr` in the same cycle, with bit 0 the locked flag and bit 1 the locked-down flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; relocks every block |
| wp_n | input | 1 | Write-protect pin; low keeps locked-down blocks locked |
| cmd_we | input | 1 | Configuration write strobe |
| cmd_addr | input | 22 | Word address of the configuration write |
| cmd_data | input | 8 | Setup or confirm code |
| seq_err | output | 1 | Pulse one cycle after a bad confirm code |
| st_addr | input | 22 | Address whose block flags are shown |
| st_flags | output | 2 | {locked-down, locked} of that block |
| pe_req | input | 1 | Program/erase permit request |
| pe_addr | input | 22 | Target address of the request |
| pe_grant | output | 1 | Request allowed (one cycle later) |
| pe_deny | output | 1 | Request refused: protected block |

## Verification
Two functions can fall in the same cycle: a confirm that changes a block's flags, and a permit request aimed at that same block. The bench provokes this by presenting a D0h confirm and a `pe_req` to one locked block on the same edge. It expects a deny, because the state before the confirm applies. A second request, made afterwards, must then be granted. The other corner is the meeting of `wp_n` with a locked-down block during an unlock. This is swept over every block with the pin low and then high, and each result is compared against an arithmetic model of the flags.

// File: rtl/lkm_pkg.sv
package lkm_pkg;

  localparam logic [7:0] CODE_SETUP  = 8'h60;
  localparam logic [7:0] CODE_LOCK   = 8'h01;
  localparam logic [7:0] CODE_UNLOCK = 8'hD0;
  localparam logic [7:0] CODE_DOWN   = 8'h2F;

  typedef enum logic [1:0] {OP_NONE, OP_LOCK, OP_UNLOCK, OP_DOWN} cfg_op_e;

  // bit 1 = locked-down, bit 0 = locked
  typedef struct packed {
    logic down;
    logic locked;
  } prot_t;

  localparam prot_t PROT_RESET = '{down: 1'b0, locked: 1'b1};

  function automatic cfg_op_e decode_confirm(logic [7:0] code);
    case (code)
      CODE_LOCK:   return OP_LOCK;
      CODE_UNLOCK: return OP_UNLOCK;
      CODE_DOWN:   return OP_DOWN;
      default:     return OP_NONE;
    endcase
  endfunction

  function automatic prot_t prot_next(prot_t cur, cfg_op_e op, logic wp_n);
    prot_t nxt;
    nxt = cur;
    case (op)
      OP_LOCK:   nxt.locked = 1'b1;
      OP_DOWN:   begin nxt.locked = 1'b1; nxt.down = 1'b1; end
      OP_UNLOCK: if (!(cur.down && !wp_n)) nxt.locked = 1'b0;
      default:   ;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/lkm_blkmap.sv
module lkm_blkmap #(
  parameter int ADDR_W      = 22,
  parameter int MAIN_SHIFT  = 15,
  parameter int PARAM_SHIFT = 12,
  parameter int IDX_W       = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);
  localparam int NUM_MAIN = (1 << (ADDR_W - MAIN_SHIFT)) - 1;

  function automatic logic [IDX_W-1:0] blk_of(logic [ADDR_W-1:0] a);
    logic [ADDR_W-MAIN_SHIFT-1:0]     hi;
    logic [MAIN_SHIFT-PARAM_SHIFT-1:0] sub;
    hi  = a[ADDR_W-1:MAIN_SHIFT];
    sub = a[MAIN_SHIFT-1:PARAM_SHIFT];
    if (&hi) return IDX_W'(NUM_MAIN) + IDX_W'(sub);
    return IDX_W'(hi);
  endfunction

  logic unused_lo;
  assign unused_lo = ^addr[PARAM_SHIFT-1:0];
  assign idx = blk_of(addr);
endmodule

// File: rtl/lkm_cfgseq.sv
module lkm_cfgseq
  import lkm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_we,
  input  logic [7:0] cmd_data,
  output cfg_op_e    op,
  output logic       bad_cfg
);
  logic armed_q;
  logic confirm;

  assign confirm = cmd_we && armed_q;
  assign op      = confirm ? decode_confirm(cmd_data) : OP_NONE;
  assign bad_cfg = confirm && (decode_confirm(cmd_data) == OP_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       armed_q <= 1'b0;
    else if (cmd_we)  armed_q <= !armed_q && (cmd_data == CODE_SETUP);
  end
endmodule

// File: rtl/lkm_bank.sv
module lkm_bank
  import lkm_pkg::*;
#(
  parameter int NUM_BLK = 135,
  parameter int IDX_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wp_n,
  input  cfg_op_e          op,
  input  logic [IDX_W-1:0] op_idx,
  input  logic [IDX_W-1:0] st_idx,
  input  logic [IDX_W-1:0] pe_idx,
  output prot_t            cmd_cur,
  output prot_t            upd_flags,
  output prot_t            st_cur,
  output prot_t            pe_cur
);
  prot_t cells [NUM_BLK];

  assign cmd_cur   = cells[op_idx];
  assign st_cur    = cells[st_idx];
  assign pe_cur    = cells[pe_idx];
  assign upd_flags = prot_next(cmd_cur, op, wp_n);

  for (genvar g = 0; g < NUM_BLK; g++) begin : g_blk
    prot_t cell_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cell_q <= PROT_RESET;
      else if (op != OP_NONE && op_idx == IDX_W'(g)) cell_q <= upd_flags;
    end
    assign cells[g] = cell_q;
  end
endmodule

// File: rtl/lkm_top.sv
module lkm_top
  import lkm_pkg::*;
#(
  parameter int ADDR_W      = 22,
  parameter int MAIN_SHIFT  = 15,
  parameter int PARAM_SHIFT = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n,
  input  logic              cmd_we,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  output logic              seq_err,
  input  logic [ADDR_W-1:0] st_addr,
  output logic [1:0]        st_flags,
  input  logic              pe_req,
  input  logic [ADDR_W-1:0] pe_addr,
  output logic              pe_grant,
  output logic              pe_deny
);
  localparam int NUM_MAIN  = (1 << (ADDR_W - MAIN_SHIFT)) - 1;
  localparam int NUM_PARAM = 1 << (MAIN_SHIFT - PARAM_SHIFT);
  localparam int NUM_BLK   = NUM_MAIN + NUM_PARAM;
  localparam int IDX_W     = $clog2(NUM_BLK);

  logic [IDX_W-1:0] cmd_idx, st_idx, pe_idx;
  cfg_op_e          op;
  logic             bad_cfg;
  prot_t            cmd_cur, upd_flags, st_cur, pe_cur;

  lkm_blkmap #(.ADDR_W(ADDR_W), .MAIN_SHIFT(MAIN_SHIFT), .PARAM_SHIFT(PARAM_SHIFT), .IDX_W(IDX_W))
    u_map_cmd (.addr(cmd_addr), .idx(cmd_idx));
  lkm_blkmap #(.ADDR_W(ADDR_W), .MAIN_SHIFT(MAIN_SHIFT), .PARAM_SHIFT(PARAM_SHIFT), .IDX_W(IDX_W))
    u_map_st (.addr(st_addr), .idx(st_idx));
  lkm_blkmap #(.ADDR_W(ADDR_W), .MAIN_SHIFT(MAIN_SHIFT), .PARAM_SHIFT(PARAM_SHIFT), .IDX_W(IDX_W))
    u_map_pe (.addr(pe_addr), .idx(pe_idx));

  lkm_cfgseq u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_data(cmd_data),
    .op(op), .bad_cfg(bad_cfg)
  );

  lkm_bank #(.NUM_BLK(NUM_BLK), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .op(op), .op_idx(cmd_idx),
    .st_idx(st_idx), .pe_idx(pe_idx), .cmd_cur(cmd_cur), .upd_flags(upd_flags),
    .st_cur(st_cur), .pe_cur(pe_cur)
  );

  assign st_flags = st_cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_err  <= 1'b0;
      pe_grant <= 1'b0;
      pe_deny  <= 1'b0;
    end else begin
      seq_err  <= bad_cfg;
      pe_grant <= pe_req && !pe_cur.locked;
      pe_deny  <= pe_req &&  pe_cur.locked;
    end
  end
endmodule

// File: rtl/lkm_chk.sv
module lkm_chk
  import lkm_pkg::*;
(
  input logic    clk,
  input logic    rst_n,
  input logic    wp_n,
  input cfg_op_e op,
  input logic    bad_cfg,
  input prot_t   cmd_cur,
  input prot_t   upd_flags,
  input prot_t   pe_cur,
  input logic    pe_req,
  input logic    pe_grant,
  input logic    pe_deny,
  input logic    seq_err
);
  AST_PERMIT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(pe_grant && pe_deny)); // R5

  AST_PERMIT_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    pe_req |=> (pe_grant == !$past(pe_cur.locked)) && (pe_deny == $past(pe_cur.locked))); // R7

  AST_LOCK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_LOCK) |-> upd_flags.locked && (upd_flags.down == cmd_cur.down)); // R2

  AST_DOWN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_DOWN) |-> (upd_flags == 2'b11)); // R3

  AST_UNLOCK_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_UNLOCK && cmd_cur.down && !wp_n) |-> (upd_flags == cmd_cur)); // R4

  AST_UNLOCK_KEEPS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_UNLOCK && wp_n) |-> !upd_flags.locked && (upd_flags.down == cmd_cur.down)); // R4

  AST_BAD_NO_OP: assert property (@(posedge clk) disable iff (!rst_n)
    bad_cfg |-> (op == OP_NONE)); // R6

  AST_BAD_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    bad_cfg |=> seq_err); // R6

  AST_ERR_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |-> $past(bad_cfg)); // R6
endmodule

bind lkm_top lkm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .op(op), .bad_cfg(bad_cfg),
  .cmd_cur(cmd_cur), .upd_flags(upd_flags), .pe_cur(pe_cur),
  .pe_req(pe_req), .pe_grant(pe_grant), .pe_deny(pe_deny), .seq_err(seq_err)
);

// File: tb/sim_lkm_top.sv
module sim_lkm_top;
  localparam int NB = 135;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wp_n = 1'b0;
  logic        cmd_we = 1'b0;
  logic [21:0] cmd_addr = '0;
  logic [7:0]  cmd_data = '0;
  logic        seq_err;
  logic [21:0] st_addr = '0;
  logic [1:0]  st_flags;
  logic        pe_req = 1'b0;
  logic [21:0] pe_addr = '0;
  logic        pe_grant, pe_deny;

  int n_chk = 0;
  int n_fail = 0;
  bit exp_lk [NB];
  bit exp_dn [NB];

  lkm_top u0 (.*);

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int base_of(int i);
    if (i < 127) return i * 32768;
    return 32'h3F8000 + (i - 127) * 4096;
  endfunction

  function automatic int last_of(int i);
    return base_of(i) + ((i < 127) ? 32767 : 4095);
  endfunction

  function automatic int idx_of(int a);
    if (a >= 32'h3F8000) return 127 + (a - 32'h3F8000) / 4096;
    return a / 32768;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NB; i++) begin exp_lk[i] = 1; exp_dn[i] = 0; end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    cmd_we = 1; cmd_addr = 22'(a); cmd_data = d;
    @(negedge clk);
    cmd_we = 0;
  endtask

  task automatic cfg(input int i, input logic [7:0] code);
    wr(0, 8'h60);
    wr(base_of(i) + 5, code);
    case (code)
      8'h01: exp_lk[i] = 1;
      8'h2F: begin exp_lk[i] = 1; exp_dn[i] = 1; end
      8'hD0: if (wp_n || !exp_dn[i]) exp_lk[i] = 0;
      default: ;
    endcase
  endtask

  task automatic sweep_status(input string req);
    for (int i = 0; i < NB; i++) begin
      st_addr = 22'(base_of(i)); #1;
      chk(st_flags == {exp_dn[i], exp_lk[i]}, req, st_flags, {exp_dn[i], exp_lk[i]});
      st_addr = 22'(last_of(i)); #1;
      chk(st_flags == {exp_dn[i], exp_lk[i]}, {req, " R8 last-word"}, st_flags, {exp_dn[i], exp_lk[i]});
    end
  endtask

  task automatic sweep_pe(input string req);
    for (int i = 0; i < NB; i++) begin
      @(negedge clk);
      pe_req = 1; pe_addr = 22'(base_of(i) + 1);
      @(negedge clk);
      pe_req = 0;
      chk(pe_grant == !exp_lk[i] && pe_deny == exp_lk[i], req, {pe_grant, pe_deny}, {!exp_lk[i], exp_lk[i]});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog all-requirements actual=hang expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    sweep_status("R1 reset-held");
    rst_n = 1;
    // R8: mapping boundary between the last large block and the first small block
    chk(idx_of(32'h3F7FFF) == 126 && idx_of(32'h3F8000) == 127, "R8 model", 0, 0);
    sweep_status("R1 R9 after reset");
    sweep_pe("R5 all locked deny");

    // R2: a bare confirm without setup changes nothing
    wr(base_of(4), 8'hD0);
    st_addr = 22'(base_of(4)); #1;
    chk(st_flags == 2'b01, "R2 bare confirm ignored", st_flags, 2'b01);

    // R4 wp low: unlock even blocks, lock-down every third
    for (int i = 0; i < NB; i += 2) cfg(i, 8'hD0);
    for (int i = 0; i < NB; i += 3) cfg(i, 8'h2F);
    sweep_status("R3 R4 unlock and down");
    for (int i = 0; i < NB; i++) cfg(i, 8'hD0);
    sweep_status("R4 wp low unlock refused on down");
    sweep_pe("R5 permit with wp low");

    // R4 wp high: down blocks can be unlocked, down flag kept
    wp_n = 1;
    for (int i = 0; i < NB; i += 3) cfg(i, 8'hD0);
    sweep_status("R4 wp high unlock");
    sweep_pe("R5 down alone grants");

    // R2 relock a few, including small blocks
    cfg(1, 8'h01); cfg(130, 8'h01); cfg(134, 8'h01);
    sweep_status("R2 relock");

    // R6 bad confirm
    wr(0, 8'h60);
    @(negedge clk);
    cmd_we = 1; cmd_addr = 22'(base_of(2)); cmd_data = 8'h55;
    @(negedge clk);
    cmd_we = 0;
    chk(seq_err == 1'b1, "R6 seq_err raised", seq_err, 1);
    @(negedge clk);
    chk(seq_err == 1'b0, "R6 seq_err one cycle", seq_err, 0);
    sweep_status("R6 no change after bad code");

    // R7 same-cycle confirm and permit on locked block 1
    wr(0, 8'h60);
    @(negedge clk);
    cmd_we = 1; cmd_addr = 22'(base_of(1)); cmd_data = 8'hD0;
    pe_req = 1; pe_addr = 22'(base_of(1));
    @(negedge clk);
    cmd_we = 0; pe_req = 0;
    exp_lk[1] = 0;
    chk(pe_deny == 1'b1 && pe_grant == 1'b0, "R7 old state decides", {pe_grant, pe_deny}, 2'b01);
    @(negedge clk);
    pe_req = 1;
    @(negedge clk);
    pe_req = 0;
    chk(pe_grant == 1'b1 && pe_deny == 1'b0, "R7 new state next request", {pe_grant, pe_deny}, 2'b10);

    // R1 reset again: lock-downs revert, everything locked
    @(negedge clk);
    rst_n = 0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
    sweep_status("R1 reset reverts down");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule